// File: doc/BRIEF.md
# Ordered Partition History Matcher

This block judges whether the coherence-state history that one private cache recorded for a line fits the history that the shared cache recorded for the same line. Each history is a sequence of 2-bit MESI codes. Both are written into internal buffers through a simple write port. Each buffer holds up to `DEPTH` entries, and each history comes with its own valid length. A start pulse launches the check.

The check works in two passes. The first pass walks the local history once. It folds write-contention bursts, where M or E alternates with invalid, down to a single M or E, and it stores the result in a scratch buffer. The second pass treats every maximal run of non-invalid codes in that scratch buffer as one segment. It looks for each segment, in order, as a contiguous and non-overlapping substring of the shared history, placing each segment at its leftmost possible position. A one-cycle done pulse then returns one of three verdicts: compatible, incompatible (a coherence error), or skipped. Skipped means the cycle budget ran out before a verdict was reached.

A MOESI owner state is written into the buffers as S by whatever records the history, so the block only ever sees four codes.

Top module: `partition_history_matcher`

## Requirements
- R1: State codes are I=0, S=1, E=2, M=3. A write with `wrShared`=0 stores `wrData` at `wrAddr` of the local buffer, and a write with `wrShared`=1 stores it in the shared buffer. `locLen` and `shLen` are sampled on the start cycle and are clamped to `DEPTH`.
- R2: Before matching, any run of the form X I X I ... X, with X being M or E throughout, counts as a single X (for example MIMIM acts as M). A run that mixes M and E across an I is not folded.
- R3: After folding, the local history is cut at every I. The I codes are discarded, and each maximal run of non-I codes is one segment.
- R4: The verdict is 0 (compatible) when every segment occurs as a contiguous substring of the shared history, with the segments appearing in local order and not overlapping.
- R5: The verdict is 1 (incompatible) when some segment cannot be placed after the segments before it. The verdict code 3 never appears.
- R6: A local history with no segments, meaning it is empty or holds only I, gives verdict 0.
- R7: When a check has not finished within `BUDGET` busy cycles (10000 by default), it ends with verdict 2 (skipped).
- R8: `busy` rises the cycle after an accepted start. `done` pulses for exactly one cycle, in the cycle where `busy` falls, and `result` carries the verdict. A start while busy is ignored.
- R9: Writes are ignored while busy. A write in the same cycle as an accepted start is stored and is seen by that check.
- R10: After reset, `busy`, `done` and `result` are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wrEn | input | 1 | Write strobe for a history entry |
| wrShared | input | 1 | 1 selects the shared buffer, 0 the local buffer |
| wrAddr | input | AW | Entry index |
| wrData | input | 2 | State code |
| locLen | input | LW | Local history length, sampled at start |
| shLen | input | LW | Shared history length, sampled at start |
| start | input | 1 | Launch a check |
| busy | output | 1 | Check in progress |
| done | output | 1 | One-cycle verdict strobe |
| result | output | 2 | 0 compatible, 1 incompatible, 2 skipped |

## Verification
Two things can land in the same cycle: a buffer write and the start that launches the check. A second collision, a write or a restart arriving while a check is running, must have no effect. The bench provokes the first case by issuing the last local write together with start. It then judges the verdict, which only comes out compatible if the new code was used. It provokes the second case by writing a different code, and by re-pulsing start with a length that would flip the verdict, in the first busy cycle. A later rerun with untouched inputs must return the original verdict. Random histories, many built by embedding the local segments into noise, are compared against a bench model. That model folds by repeated pattern rewriting and then places segments by plain substring search.

// File: rtl/histmatch_pkg.sv
package histmatch_pkg;

  typedef enum logic [1:0] {
    ST_I = 2'd0,
    ST_S = 2'd1,
    ST_E = 2'd2,
    ST_M = 2'd3
  } cohState_t;

  typedef enum logic [1:0] {
    VERD_OK   = 2'd0,
    VERD_BAD  = 2'd1,
    VERD_SKIP = 2'd2
  } verdict_t;

  // strobes from control to datapath
  typedef struct packed {
    logic idle;
    logic latch;
    logic compStep;
    logic cPosInc;
    logic partBegin;
    logic partAccept;
    logic kInc;
    logic slide;
  } dpCtl_t;

  // conditions reported by the datapath
  typedef struct packed {
    logic compDone;
    logic allDone;
    logic atIState;
    logic partEnd;
    logic shOut;
    logic symEq;
  } dpFlag_t;

endpackage

// File: rtl/hm_datapath.sv
module hm_datapath
  import histmatch_pkg::*;
#(
  parameter int DEPTH = 256,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  dpCtl_t        ctl,
  input  logic          wrEn,
  input  logic          wrShared,
  input  logic [AW-1:0] wrAddr,
  input  logic [1:0]    wrData,
  input  logic [LW-1:0] locLen,
  input  logic [LW-1:0] shLen,
  output dpFlag_t       flag
);

  localparam logic [LW-1:0] DEPTH_L = LW'(DEPTH);

  logic [1:0] locMem  [DEPTH];
  logic [1:0] shMem   [DEPTH];
  logic [1:0] compMem [DEPTH];

  logic [LW-1:0] locLenR, shLenR;
  logic [LW-1:0] cIdx, compLen, cPos, k, sPos, shBase;

  // history writes are accepted only while idle
  always_ff @(posedge clk) begin
    if (wrEn && ctl.idle && !wrShared) locMem[wrAddr] <= wrData;
  end

  always_ff @(posedge clk) begin
    if (wrEn && ctl.idle && wrShared) shMem[wrAddr] <= wrData;
  end

  // folding pass
  logic [1:0]    locSym, prev1, prev2;
  logic [LW-1:0] cm1, cm2;
  logic          fold;

  assign cm1    = compLen - 1'b1;
  assign cm2    = compLen - 2'd2;
  assign locSym = locMem[cIdx[AW-1:0]];
  assign prev1  = compMem[cm1[AW-1:0]];
  assign prev2  = compMem[cm2[AW-1:0]];
  assign fold   = (compLen >= LW'(2)) &&
                  (locSym == ST_M || locSym == ST_E) &&
                  (prev1 == ST_I) && (prev2 == locSym);

  always_ff @(posedge clk) begin
    if (ctl.compStep && !fold) compMem[compLen[AW-1:0]] <= locSym;
  end

  // segment search
  logic [LW:0] curIdx, shIdx;
  logic [1:0]  curSym, shSym, seekSym;

  assign curIdx  = {1'b0, cPos} + {1'b0, k};
  assign shIdx   = {1'b0, sPos} + {1'b0, k};
  assign curSym  = compMem[curIdx[AW-1:0]];
  assign shSym   = shMem[shIdx[AW-1:0]];
  assign seekSym = compMem[cPos[AW-1:0]];

  assign flag.compDone = (cIdx >= locLenR);
  assign flag.allDone  = (cPos >= compLen);
  assign flag.atIState = (seekSym == ST_I);
  assign flag.partEnd  = (curIdx >= {1'b0, compLen}) || (curSym == ST_I);
  assign flag.shOut    = (shIdx >= {1'b0, shLenR});
  assign flag.symEq    = (curSym == shSym);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      locLenR <= '0;
      shLenR  <= '0;
      cIdx    <= '0;
      compLen <= '0;
      cPos    <= '0;
      k       <= '0;
      sPos    <= '0;
      shBase  <= '0;
    end else begin
      if (ctl.latch) begin
        locLenR <= (locLen > DEPTH_L) ? DEPTH_L : locLen;
        shLenR  <= (shLen  > DEPTH_L) ? DEPTH_L : shLen;
        cIdx    <= '0;
        compLen <= '0;
        cPos    <= '0;
        shBase  <= '0;
      end
      if (ctl.compStep) begin
        cIdx    <= cIdx + 1'b1;
        compLen <= fold ? cm1 : compLen + 1'b1;
      end
      if (ctl.cPosInc) cPos <= cPos + 1'b1;
      if (ctl.partBegin) begin
        sPos <= shBase;
        k    <= '0;
      end
      if (ctl.partAccept) begin
        cPos   <= curIdx[LW-1:0];
        shBase <= shIdx[LW-1:0];
      end
      if (ctl.kInc) k <= k + 1'b1;
      if (ctl.slide) begin
        sPos <= sPos + 1'b1;
        k    <= '0;
      end
    end
  end

  AST_FOLD_SHRINKS: assert property (@(posedge clk) disable iff (!rstN)
    compLen <= cIdx); // R2
  AST_BASE_IN_RANGE: assert property (@(posedge clk) disable iff (!rstN)
    shBase <= shLenR); // R4
  AST_LEN_CLAMP: assert property (@(posedge clk) disable iff (!rstN)
    locLenR <= DEPTH_L && shLenR <= DEPTH_L); // R1

endmodule

// File: rtl/hm_ctrl.sv
module hm_ctrl
  import histmatch_pkg::*;
#(
  parameter int BUDGET = 10000,
  localparam int BW = $clog2(BUDGET + 1)
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       start,
  input  dpFlag_t    flag,
  output dpCtl_t     ctl,
  output logic       busy,
  output logic       done,
  output logic [1:0] result
);

  typedef enum logic [1:0] {S_IDLE, S_COMP, S_SEEK, S_SCAN} phase_t;

  localparam logic [BW-1:0] LAST_CYCLE = BW'(BUDGET - 1);

  phase_t        state, nextState;
  logic [BW-1:0] budgetCnt;
  logic          finish;
  verdict_t      verdict;
  logic          doneR;
  logic [1:0]    resultR;

  always_comb begin
    ctl       = '0;
    ctl.idle  = (state == S_IDLE);
    nextState = state;
    finish    = 1'b0;
    verdict   = VERD_OK;
    unique case (state)
      S_IDLE: begin
        if (start) begin
          ctl.latch = 1'b1;
          nextState = S_COMP;
        end
      end
      S_COMP: begin
        if (flag.compDone) nextState = S_SEEK;
        else               ctl.compStep = 1'b1;
      end
      S_SEEK: begin
        if (flag.allDone) begin
          finish  = 1'b1;
          verdict = VERD_OK;
        end else if (flag.atIState) begin
          ctl.cPosInc = 1'b1;
        end else begin
          ctl.partBegin = 1'b1;
          nextState     = S_SCAN;
        end
      end
      S_SCAN: begin
        if (flag.partEnd) begin
          ctl.partAccept = 1'b1;
          nextState      = S_SEEK;
        end else if (flag.shOut) begin
          finish  = 1'b1;
          verdict = VERD_BAD;
        end else if (flag.symEq) begin
          ctl.kInc = 1'b1;
        end else begin
          ctl.slide = 1'b1;
        end
      end
      default: nextState = S_IDLE;
    endcase
    // a finished search wins over an expiring budget in the same cycle
    if (state != S_IDLE && !finish && budgetCnt == LAST_CYCLE) begin
      finish  = 1'b1;
      verdict = VERD_SKIP;
    end
    if (finish) nextState = S_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      budgetCnt <= '0;
      doneR     <= 1'b0;
      resultR   <= '0;
    end else begin
      state <= nextState;
      doneR <= finish;
      if (finish) resultR <= verdict;
      if (ctl.latch)           budgetCnt <= '0;
      else if (state != S_IDLE) budgetCnt <= budgetCnt + 1'b1;
    end
  end

  assign busy   = (state != S_IDLE);
  assign done   = doneR;
  assign result = resultR;

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done); // R8
  AST_DONE_AT_FALL: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done); // R8
  AST_RESULT_CODE: assert property (@(posedge clk) disable iff (!rstN)
    done |-> result != 2'd3); // R5
  AST_BUDGET_CAP: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> budgetCnt < BW'(BUDGET)); // R7

endmodule

// File: rtl/partition_history_matcher.sv
module partition_history_matcher
  import histmatch_pkg::*;
#(
  parameter int DEPTH  = 256,
  parameter int BUDGET = 10000,
  localparam int AW = $clog2(DEPTH),
  localparam int LW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          wrEn,
  input  logic          wrShared,
  input  logic [AW-1:0] wrAddr,
  input  logic [1:0]    wrData,
  input  logic [LW-1:0] locLen,
  input  logic [LW-1:0] shLen,
  input  logic          start,
  output logic          busy,
  output logic          done,
  output logic [1:0]    result
);

  dpCtl_t  ctl;
  dpFlag_t flag;

  hm_ctrl #(.BUDGET(BUDGET)) i_ctrl (
    .clk    (clk),
    .rstN   (rstN),
    .start  (start),
    .flag   (flag),
    .ctl    (ctl),
    .busy   (busy),
    .done   (done),
    .result (result)
  );

  hm_datapath #(.DEPTH(DEPTH)) i_datapath (
    .clk      (clk),
    .rstN     (rstN),
    .ctl      (ctl),
    .wrEn     (wrEn),
    .wrShared (wrShared),
    .wrAddr   (wrAddr),
    .wrData   (wrData),
    .locLen   (locLen),
    .shLen    (shLen),
    .flag     (flag)
  );

endmodule

// File: tb/test_partition_history_matcher.sv
`timescale 1ns/1ps
module test_partition_history_matcher;

  localparam int DEPTH = 256;
  localparam int AW = 8;
  localparam int LW = 9;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          wrEn = 1'b0;
  logic          wrShared = 1'b0;
  logic [AW-1:0] wrAddr = '0;
  logic [1:0]    wrData = '0;
  logic [LW-1:0] locLen = '0;
  logic [LW-1:0] shLen = '0;
  logic          start = 1'b0;
  logic          busy, done;
  logic [1:0]    result;

  always #2 clk = ~clk;

  partition_history_matcher i_partition_history_matcher (
    .clk(clk), .rstN(rstN), .wrEn(wrEn), .wrShared(wrShared),
    .wrAddr(wrAddr), .wrData(wrData), .locLen(locLen), .shLen(shLen),
    .start(start), .busy(busy), .done(done), .result(result)
  );

  int tests = 0;
  int failed = 0;
  bit finished = 0;
  int locA[DEPTH];
  int shA[DEPTH];
  int locN, shN;

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    tests++;
    if (!ok) begin
      failed++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  // model: fold by repeated rewriting, then leftmost substring placement
  function automatic int model();
    int c[DEPTH];
    int cn = locN;
    bit changed = 1;
    int base = 0;
    int i = 0;
    for (int j = 0; j < locN; j++) c[j] = locA[j];
    while (changed) begin
      changed = 0;
      for (int j = 0; j + 2 < cn && !changed; j++) begin
        if ((c[j] == 3 || c[j] == 2) && c[j+1] == 0 && c[j+2] == c[j]) begin
          for (int m = j + 1; m + 2 < cn; m++) c[m] = c[m+2];
          cn -= 2;
          changed = 1;
        end
      end
    end
    while (i < cn) begin
      int ps, pl;
      bit hit;
      if (c[i] == 0) begin
        i++;
        continue;
      end
      ps = i;
      while (i < cn && c[i] != 0) i++;
      pl = i - ps;
      hit = 0;
      for (int t = base; t + pl <= shN && !hit; t++) begin
        bit eq = 1;
        for (int q = 0; q < pl; q++) if (shA[t+q] != c[ps+q]) eq = 0;
        if (eq) begin
          hit = 1;
          base = t + pl;
        end
      end
      if (!hit) return 1;
    end
    return 0;
  endfunction

  task automatic writeOne(input bit sel, input int idx, input int val);
    @(negedge clk);
    wrEn = 1'b1; wrShared = sel; wrAddr = AW'(idx); wrData = 2'(val);
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic loadAll();
    for (int j = 0; j < locN; j++) writeOne(1'b0, j, locA[j]);
    for (int j = 0; j < shN; j++) writeOne(1'b1, j, shA[j]);
  endtask

  task automatic setStr(input bit sel, input string s);
    for (int j = 0; j < s.len(); j++) begin
      int v;
      case (s[j])
        "S": v = 1;
        "E": v = 2;
        "M": v = 3;
        default: v = 0;
      endcase
      if (sel) shA[j] = v; else locA[j] = v;
    end
    if (sel) shN = s.len(); else locN = s.len();
  endtask

  task automatic launch(output int verdict, output bit gotDone);
    int waitCnt = 0;
    @(negedge clk);
    start = 1'b1; locLen = LW'(locN); shLen = LW'(shN);
    @(negedge clk);
    start = 1'b0;
    while (!done && waitCnt < 20000) begin
      @(negedge clk);
      waitCnt++;
    end
    gotDone = done;
    verdict = result;
  endtask

  task automatic runCase(input int exp, input string tag);
    int v;
    bit g;
    loadAll();
    launch(v, g);
    check(g && v == exp, tag, g ? v : -1, exp);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      tests++;
      failed++;
      $display("FAIL watchdog: actual hung expected done");
      $display("  [TB] %0d tests run, %0d failed", tests, failed);
      $finish;
    end
  end

  initial begin
    int v;
    bit g;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    // R10 reset state
    check(busy == 0 && done == 0 && result == 0, "R10 reset", {busy, done, result}, 0);
    rstN = 1'b1;
    @(negedge clk);

    // R2 R3 R4 worked example: folds to IMISMI, segments M and SM
    setStr(0, "IMIMIMISMI"); setStr(1, "IMISMIM");
    runCase(0, "R4 example compatible");
    // R2 fold of M and E bursts
    setStr(0, "MIMIM"); setStr(1, "M");
    runCase(0, "R2 M burst folds");
    setStr(0, "EIEIE"); setStr(1, "SES");
    runCase(0, "R2 E burst folds");
    setStr(0, "MIE"); setStr(1, "M");
    runCase(1, "R2 mixed M/E not folded");
    // R3 split at I, I dropped
    setStr(0, "SIIM"); setStr(1, "ESEM");
    runCase(0, "R3 split segments");
    // R5 missing segment and wrong order
    setStr(0, "S"); setStr(1, "MMM");
    runCase(1, "R5 segment absent");
    setStr(0, "MIS"); setStr(1, "SM");
    runCase(1, "R5 order violated");
    setStr(0, "SIS"); setStr(1, "S");
    runCase(1, "R4 no overlap");
    // R6 empty and all-I
    locN = 0; setStr(1, "SM");
    runCase(0, "R6 empty local");
    setStr(0, "IIII"); shN = 0;
    runCase(0, "R6 all invalid local");

    // R9 write in the start cycle is seen
    setStr(0, "S"); setStr(1, "M");
    loadAll();
    @(negedge clk);
    wrEn = 1'b1; wrShared = 1'b0; wrAddr = '0; wrData = 2'd3;
    start = 1'b1; locLen = 1; shLen = 1;
    @(negedge clk);
    wrEn = 1'b0; start = 1'b0;
    while (!done) @(negedge clk);
    check(result == 0, "R9 write with start accepted", result, 0);

    // R8 R9 restart and write while busy ignored
    setStr(0, "M"); setStr(1, "S");
    loadAll();
    @(negedge clk);
    start = 1'b1; locLen = 1; shLen = 1;
    @(negedge clk);
    check(busy == 1, "R8 busy after start", busy, 1);
    start = 1'b1; locLen = 0;
    wrEn = 1'b1; wrShared = 1'b0; wrAddr = '0; wrData = 2'd1;
    @(negedge clk);
    start = 1'b0; wrEn = 1'b0;
    while (!done) @(negedge clk);
    check(result == 1, "R8 restart while busy ignored", result, 1);
    @(negedge clk);
    check(done == 0 && busy == 0, "R8 done single pulse", done, 0);
    launch(v, g);
    check(g && v == 1, "R9 busy write ignored", v, 1);

    // R1 length clamp: oversize lengths act as DEPTH
    for (int j = 0; j < DEPTH; j++) begin
      locA[j] = (j == DEPTH - 1) ? 1 : 0;
      shA[j] = (j == DEPTH - 1) ? 1 : 3;
    end
    locN = DEPTH; shN = DEPTH;
    loadAll();
    @(negedge clk);
    start = 1'b1; locLen = 9'd300; shLen = 9'd400;
    @(negedge clk);
    start = 1'b0;
    while (!done) @(negedge clk);
    check(result == 0, "R1 length clamp", result, 0);

    // R7 budget: long segment slid across a long shared history
    for (int j = 0; j < DEPTH; j++) begin
      locA[j] = (j < 128) ? 3 : 1;
      shA[j] = 3;
    end
    locN = 129; shN = DEPTH;
    runCase(2, "R7 budget skip");

    // random mix R1 R4 R5
    for (int n = 0; n < 60; n++) begin
      int e;
      locN = $urandom_range(0, 16);
      for (int j = 0; j < locN; j++) locA[j] = $urandom_range(0, 3);
      if ($urandom_range(0, 1) == 1) begin
        shN = 0;
        for (int j = 0; j < locN; j++) begin
          if ($urandom_range(0, 3) == 0 && shN < 40) begin
            shA[shN] = $urandom_range(0, 3);
            shN++;
          end
          if (locA[j] != 0) begin
            shA[shN] = locA[j];
            shN++;
          end
        end
      end else begin
        shN = $urandom_range(0, 24);
        for (int j = 0; j < shN; j++) shA[j] = $urandom_range(0, 3);
      end
      e = model();
      runCase(e, e == 0 ? "R4 random" : "R5 random");
    end

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, failed);
    $finish;
  end

endmodule